// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block gives software control of a set of general-purpose pins (128 by default) through a plain 32-bit register port. The port has a byte address, a write strobe, write data and combinational read data. Each pin owns one 32-bit configuration word. In that word software chooses whether the pin drives, the level it drives, how its input raises an interrupt, and whether its receiver is gated off. The same word also shows the pin's synchronized input level.

Interrupt events collect in sticky status registers that hold 32 pins per word. Each status word has a matching enable word. A single interrupt line is raised while any pin has both its status bit and its enable bit set. A set of lock words lets the configuration of chosen pins be frozen until the next reset. Software reads the first word of the register map to learn where the per-pin words begin.

Top module: `gpio_host_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pin word reads 0x0880_0008: bit 27 host-owned = 1, bits 23:22 receive mode = 2 (off), bit 3 output-off = 1, all other bits 0. All lock, status and enable bits are 0, `irq` is 0 and `pin_oe` is all zero.
- R2: Address 0x000 reads the byte offset of the first pin word, which is 0x100 by default, and writes to it are ignored. The word for pin p sits at 0x100 + 4p. Addresses with nonzero bits 1:0, and addresses that are not mapped, read 0 and ignore writes.
- R3: Lock word k at 0x04 + 4k uses bit n to lock pin 32k+n. Writing a 1 sets a lock bit, writing a 0 leaves it unchanged, and only reset clears it. A write to the word of a locked pin leaves that word unchanged.
- R4: In a pin word, bits 27, 23:22, 21:14, 4, 3 and 0 can be written and read back. The other bits read 0. Bit 1 is read-only: it shows the synchronized input, or 0 while bit 4 (receiver off) is set.
- R5: `pin_oe[p]` is the inverse of bit 3 of pin p's word, and `pin_out[p]` equals bit 0 of that word. Both change only after a write.
- R6: A change on `pin_in[p]` that is present at one rising clock edge shows in bit 1 after the following edge, that is, two edges in total.
- R7: In receive mode 0 (level), the status bit is set on every cycle in which the gated synchronized input is high. When a set and a clear land in the same cycle, the set wins, so clearing the bit while the input stays high leaves it set.
- R8: In receive mode 1 (rising edge), the status bit is set only in the cycle in which the gated synchronized input goes from 0 to 1. Once cleared, the bit stays clear while the input stays high.
- R9: Receive modes 2 and 3 never set a status bit.
- R10: A pin whose bits 21:14 (interrupt select) are all zero never sets its status bit, whatever its mode and input.
- R11: Status word k at 0x14 + 4k and enable word k at 0x24 + 4k hold pin 32k+n at bit n. Writing a 1 to a status bit clears it. Enable words are plain read/write.
- R12: `irq` is high exactly when some pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 128 | Asynchronous pin inputs |
| pin_out | output | 128 | Output level for each pin |
| pin_oe | output | 128 | Output enable for each pin |
| irq | output | 1 | Interrupt request, level high |

## Verification
A corrupted pin word shows on `pin_out` or `pin_oe` in the cycle after the write that caused it, and on a read of that word at once. A wrong synchronizer or edge-history flop shows as a status bit set one cycle early or late, as a missing or extra set in edge mode, or as a bit 1 read that disagrees with the input delayed by two edges. A lost lock or status bit shows on `irq` or on a read of the status word within one cycle. For this reason the bench compares the pin outputs and `irq` against its own model on every clock, and compares register reads whenever it makes them.

// File: rtl/gpio_host_pkg.sv
// gpio_host_pkg: field positions, reset values and register offsets that are
// shared by the GPIO controller, its submodules and its checker.
// Assumes 32-bit registers and at most four status/enable/lock words.
package gpio_host_pkg;

    localparam int REG_W     = 32;
    localparam int PINS_PER_WORD = 32;

    // Pin configuration word field positions
    localparam int OWN_BIT   = 27;
    localparam int MODE_HI   = 23;
    localparam int MODE_LO   = 22;
    localparam int ISEL_HI   = 21;
    localparam int ISEL_LO   = 14;
    localparam int RXOFF_BIT = 4;
    localparam int TXOFF_BIT = 3;
    localparam int RXVAL_BIT = 1;
    localparam int TXVAL_BIT = 0;

    localparam logic [REG_W-1:0] PAD_WR_MASK = 32'h08FF_C019;
    localparam logic [REG_W-1:0] PAD_RST_VAL = 32'h0880_0008;

    // Register offsets (bytes)
    localparam int OFS_PADPTR = 'h00;
    localparam int OFS_LOCK   = 'h04;
    localparam int OFS_STAT   = 'h14;
    localparam int OFS_EN     = 'h24;

    typedef enum logic [1:0] {
        RXM_LEVEL = 2'd0,
        RXM_EDGE  = 2'd1,
        RXM_OFF   = 2'd2,
        RXM_RSVD  = 2'd3
    } rx_mode_e;

endpackage

// File: rtl/gpio_pad_bank.sv
// gpio_pad_bank: per-pin configuration words and sticky lock bits.
// Assumes the caller has already decoded a pin word hit (wr_pad, wr_idx) and
// one-hot lock word selects. Stored words keep only writable bits.
module gpio_pad_bank
    import gpio_host_pkg::*;
#(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS),
    localparam int NREG    = NUM_PINS / PINS_PER_WORD
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_pad,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [NREG-1:0]                  lock_wr,
    input  logic [REG_W-1:0]                 wdata,
    output logic [NUM_PINS-1:0][REG_W-1:0]   cfg_q,
    output logic [NUM_PINS-1:0]              lock_q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int WORD = p / PINS_PER_WORD;
        localparam int BIT  = p % PINS_PER_WORD;

        logic [REG_W-1:0] word_q;
        logic             lock_b;

        // Lock bit: set by writing a one, cleared only by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_b <= 1'b0;
            else if (lock_wr[WORD] && wdata[BIT])
                lock_b <= 1'b1;
        end

        // Configuration word: written when addressed and not locked
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= PAD_RST_VAL;
            else if (wr_pad && (wr_idx == IDX_W'(p)) && !lock_b)
                word_q <= wdata & PAD_WR_MASK;
        end

        assign cfg_q[p]  = word_q;
        assign lock_q[p] = lock_b;
    end

endmodule

// File: rtl/gpio_rx_detect.sv
// gpio_rx_detect: two-flop input synchronizer, receiver gating and
// per-pin level-high / rising-edge event detection.
// Assumes pin_in is asynchronous; events are single-cycle pulses per clock.
module gpio_rx_detect
    import gpio_host_pkg::*;
#(
    parameter int NUM_PINS = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pin_in,
    input  logic [NUM_PINS-1:0]       rx_off,
    input  logic [NUM_PINS-1:0][1:0]  rx_mode,
    input  logic [NUM_PINS-1:0]       isel_nz,
    output logic [NUM_PINS-1:0]       rx_val,
    output logic [NUM_PINS-1:0]       evt
);

    logic [NUM_PINS-1:0] sync1_q, sync2_q, hist_q;

    // Synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    assign rx_val = sync2_q & ~rx_off;

    // Previous gated value, used for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= rx_val;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_det
        logic hit;

        // Mode decode: which condition counts as an event for this pin
        always_comb begin
            case (rx_mode[p])
                RXM_LEVEL: hit = rx_val[p];
                RXM_EDGE:  hit = rx_val[p] & ~hist_q[p];
                default:   hit = 1'b0;
            endcase
        end

        assign evt[p] = hit & isel_nz[p];
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// gpio_irq_bank: sticky status words (write-one-to-clear) and enable words,
// plus the combined interrupt request.
// Assumes a new event wins over a clear that lands in the same cycle.
module gpio_irq_bank
    import gpio_host_pkg::*;
#(
    parameter int NUM_PINS = 128,
    localparam int NREG    = NUM_PINS / PINS_PER_WORD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  evt,
    input  logic [NREG-1:0]      stat_wr,
    input  logic [NREG-1:0]      en_wr,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_PINS-1:0]  stat_q,
    output logic [NUM_PINS-1:0]  en_q,
    output logic                 irq
);

    for (genvar k = 0; k < NREG; k++) begin : g_word
        logic [PINS_PER_WORD-1:0] st_w, en_w, clr_w;

        assign clr_w = stat_wr[k] ? wdata : '0;

        // Status word: hold, clear written ones, then merge new events
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_w <= '0;
            else
                st_w <= (st_w & ~clr_w) | evt[k*PINS_PER_WORD +: PINS_PER_WORD];
        end

        // Enable word: plain register
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_w <= '0;
            else if (en_wr[k])
                en_w <= wdata;
        end

        assign stat_q[k*PINS_PER_WORD +: PINS_PER_WORD] = st_w;
        assign en_q[k*PINS_PER_WORD +: PINS_PER_WORD]   = en_w;
    end

    assign irq = |(stat_q & en_q);

endmodule

// File: rtl/gpio_host_ctrl.sv
// gpio_host_ctrl: register-mapped GPIO controller top. Decodes the 32-bit
// register port, ties pin words to pin drivers, the input detector and the
// interrupt bank, and returns combinational read data.
// Assumes NUM_PINS is a multiple of 32 and at most 128, and that the pin word
// window starting at PAD_BASE fits inside ADDR_W bits above offset 0x30.
module gpio_host_ctrl
    import gpio_host_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] PAD_BASE = 12'h100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic                 irq
);

    localparam int IDX_W = $clog2(NUM_PINS);
    localparam int NREG  = NUM_PINS / PINS_PER_WORD;
    localparam logic [ADDR_W-3:0] NPIN_W = (ADDR_W-2)'(NUM_PINS);

    logic                  aligned;
    logic                  ptr_sel;
    logic [NREG-1:0]       lock_sel, stat_sel, en_sel;
    logic [ADDR_W-3:0]     pad_wi;
    logic                  pad_hit;
    logic [IDX_W-1:0]      pad_idx;

    logic [NUM_PINS-1:0][REG_W-1:0] cfg_q;
    logic [NUM_PINS-1:0][REG_W-1:0] pad_word;
    logic [NUM_PINS-1:0]            lock_q, stat_q, en_q;
    logic [NUM_PINS-1:0]            rx_off, isel_nz, rx_val, evt;
    logic [NUM_PINS-1:0][1:0]       rx_mode;

    // ---------------- address decode ----------------
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ptr_sel = aligned && (bus_addr == ADDR_W'(OFS_PADPTR));

    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign lock_sel[k] = aligned && (bus_addr == ADDR_W'(OFS_LOCK + 4*k));
        assign stat_sel[k] = aligned && (bus_addr == ADDR_W'(OFS_STAT + 4*k));
        assign en_sel[k]   = aligned && (bus_addr == ADDR_W'(OFS_EN   + 4*k));
    end

    assign pad_wi  = bus_addr[ADDR_W-1:2] - PAD_BASE[ADDR_W-1:2];
    assign pad_hit = aligned && (bus_addr >= PAD_BASE) && (pad_wi < NPIN_W);
    assign pad_idx = pad_wi[IDX_W-1:0];

    // ---------------- submodules ----------------
    gpio_pad_bank #(.NUM_PINS(NUM_PINS)) u_pads (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_pad  (bus_wr && pad_hit),
        .wr_idx  (pad_idx),
        .lock_wr (bus_wr ? lock_sel : '0),
        .wdata   (bus_wdata),
        .cfg_q   (cfg_q),
        .lock_q  (lock_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_fields
        assign rx_off[p]  = cfg_q[p][RXOFF_BIT];
        assign rx_mode[p] = cfg_q[p][MODE_HI:MODE_LO];
        assign isel_nz[p] = |cfg_q[p][ISEL_HI:ISEL_LO];
        assign pin_out[p] = cfg_q[p][TXVAL_BIT];
        assign pin_oe[p]  = ~cfg_q[p][TXOFF_BIT];
        assign pad_word[p] = cfg_q[p] | (REG_W'(rx_val[p]) << RXVAL_BIT);
    end

    gpio_rx_detect #(.NUM_PINS(NUM_PINS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .rx_off  (rx_off),
        .rx_mode (rx_mode),
        .isel_nz (isel_nz),
        .rx_val  (rx_val),
        .evt     (evt)
    );

    gpio_irq_bank #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .stat_wr (bus_wr ? stat_sel : '0),
        .en_wr   (bus_wr ? en_sel : '0),
        .wdata   (bus_wdata),
        .stat_q  (stat_q),
        .en_q    (en_q),
        .irq     (irq)
    );

    // ---------------- read mux ----------------
    // Read data: select the addressed register, zero when unmapped
    always_comb begin
        bus_rdata = '0;
        if (ptr_sel)
            bus_rdata = REG_W'(PAD_BASE);
        for (int k = 0; k < NREG; k++) begin
            if (lock_sel[k]) bus_rdata = lock_q[k*PINS_PER_WORD +: PINS_PER_WORD];
            if (stat_sel[k]) bus_rdata = stat_q[k*PINS_PER_WORD +: PINS_PER_WORD];
            if (en_sel[k])   bus_rdata = en_q[k*PINS_PER_WORD +: PINS_PER_WORD];
        end
        if (pad_hit)
            bus_rdata = pad_word[pad_idx];
    end

endmodule

// File: rtl/gpio_host_ctrl_chk.sv
// gpio_host_ctrl_chk: assertion checker bound into gpio_host_ctrl.
// Watches lock stickiness, locked-word protection, the interrupt-select gate,
// pin output stability and the interrupt conditions.
module gpio_host_ctrl_chk
    import gpio_host_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int IDX_W    = 7
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic                            pad_hit,
    input logic [IDX_W-1:0]                pad_idx,
    input logic [NUM_PINS-1:0][REG_W-1:0]  cfg_q,
    input logic [NUM_PINS-1:0]             lock_q,
    input logic [NUM_PINS-1:0]             stat_q,
    input logic [NUM_PINS-1:0]             en_q,
    input logic [NUM_PINS-1:0]             isel_nz,
    input logic [NUM_PINS-1:0]             pin_out,
    input logic [NUM_PINS-1:0]             pin_oe,
    input logic                            irq
);

    logic                 past_ok;
    logic                 lk_hit_q;
    logic [IDX_W-1:0]     lk_idx_q;
    logic [REG_W-1:0]     lk_word_q;
    logic [NUM_PINS-1:0]  lock_prev, stat_prev, isel_prev;

    // History registers for the properties below
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            lk_hit_q  <= 1'b0;
            lk_idx_q  <= '0;
            lk_word_q <= '0;
            lock_prev <= '0;
            stat_prev <= '0;
            isel_prev <= '0;
        end else begin
            past_ok   <= 1'b1;
            lk_hit_q  <= bus_wr && pad_hit && lock_q[pad_idx];
            lk_idx_q  <= pad_idx;
            lk_word_q <= cfg_q[pad_idx];
            lock_prev <= lock_q;
            stat_prev <= stat_q;
            isel_prev <= isel_nz;
        end
    end

    // R3: a write to a locked pin word leaves it unchanged
    a_r3_locked_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_q |-> (cfg_q[lk_idx_q] == lk_word_q));

    // R3: lock bits never fall outside reset
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((lock_prev & ~lock_q) == '0));

    // R10: a status bit only rises for pins with a nonzero interrupt select
    a_r10_isel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((stat_q & ~stat_prev & ~isel_prev) == '0));

    // R5: pin drivers only move after a write
    a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_wr)) |-> ($stable(pin_oe) && $stable(pin_out)));

    // R12: no request without an enable bit
    a_r12_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    // R12: no request without a status bit
    a_r12_irq_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);

endmodule

bind gpio_host_ctrl gpio_host_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .pad_hit (pad_hit),
    .pad_idx (pad_idx),
    .cfg_q   (cfg_q),
    .lock_q  (lock_q),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .isel_nz (isel_nz),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/sim_gpio_host_ctrl.sv
// sim_gpio_host_ctrl: bench with a behavioural reference model updated on every
// rising edge; pin outputs and irq are compared each clock, reads on demand.
module sim_gpio_host_ctrl;

    localparam int NP = 128;
    localparam logic [31:0] WMASK = 32'h08FF_C019;
    localparam logic [31:0] RSTW  = 32'h0880_0008;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_host_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0]   m_cfg [NP];
    logic [NP-1:0] m_lock, m_stat, m_en, m_s1, m_s2, m_prev;

    always @(posedge clk) begin : model
        logic [NP-1:0] g, ev, clr;
        int a, base, idx;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) m_cfg[p] = RSTW;
            m_lock = '0; m_stat = '0; m_en = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                g[p] = m_s2[p] & ~m_cfg[p][4];
                ev[p] = 1'b0;
                if (m_cfg[p][21:14] != 0) begin
                    if (m_cfg[p][23:22] == 2'd0) ev[p] = g[p];
                    if (m_cfg[p][23:22] == 2'd1) ev[p] = g[p] & ~m_prev[p];
                end
            end
            clr = '0;
            a = int'(bus_addr);
            if (bus_wr && (a % 4 == 0)) begin
                if (a >= 'h04 && a <= 'h10) begin
                    base = (a - 'h04) / 4 * 32;
                    m_lock[base +: 32] = m_lock[base +: 32] | bus_wdata;
                end
                if (a >= 'h14 && a <= 'h20) clr[(a - 'h14) / 4 * 32 +: 32] = bus_wdata;
                if (a >= 'h24 && a <= 'h30) m_en[(a - 'h24) / 4 * 32 +: 32] = bus_wdata;
                if (a >= 'h100 && a < 'h300) begin
                    idx = (a - 'h100) / 4;
                    if (!m_lock[idx]) m_cfg[idx] = bus_wdata & WMASK;
                end
            end
            m_stat = (m_stat & ~clr) | ev;
            m_prev = g;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r = '0;
        if (a % 4 != 0) return '0;
        if (a == 0) r = 32'h100;
        if (a >= 'h04 && a <= 'h10) r = m_lock[(a - 'h04) / 4 * 32 +: 32];
        if (a >= 'h14 && a <= 'h20) r = m_stat[(a - 'h14) / 4 * 32 +: 32];
        if (a >= 'h24 && a <= 'h30) r = m_en[(a - 'h24) / 4 * 32 +: 32];
        if (a >= 'h100 && a < 'h300) begin
            int i = (a - 'h100) / 4;
            r = m_cfg[i] | ({31'b0, m_s2[i] & ~m_cfg[i][4]} << 1);
        end
        return r;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of pin outputs and irq (R5, R12)
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [NP-1:0] e_oe, e_out;
            for (int p = 0; p < NP; p++) begin
                e_oe[p]  = ~m_cfg[p][3];
                e_out[p] = m_cfg[p][0];
            end
            n_chk++;
            if (pin_oe !== e_oe || pin_out !== e_out || irq !== |(m_stat & m_en)) begin
                n_bad++;
                $display("FAIL R5/R12 per-clock actual oe=%h out=%h irq=%b expected oe=%h out=%h irq=%b",
                         pin_oe, pin_out, irq, e_oe, e_out, |(m_stat & m_en));
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        bus_addr = 12'(a); bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic rd_lit(input int a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = 12'(a); bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t = s;
        t ^= t << 13; t ^= t >> 17; t ^= t << 5;
        return t;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_lit('h100, "R1 pin0 reset word", RSTW);
        rd_lit('h2FC, "R1 pin127 reset word", RSTW);
        rd_lit('h14, "R1 status0 reset", 32'h0);
        rd_lit('h30, "R1 enable3 reset", 32'h0);
        rd_lit('h04, "R1 lock0 reset", 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe reset", {31'b0, |pin_oe}, 32'h0);

        // R2: pointer register, ignored write, unaligned and unmapped reads
        rd_lit('h000, "R2 pad pointer", 32'h100);
        wr('h000, 32'hFFFF_FFFF);
        rd_lit('h000, "R2 pointer after write", 32'h100);
        wr('h102, 32'h0000_0000);
        rd_lit('h100, "R2 unaligned write ignored", RSTW);
        rd_lit('h101, "R2 unaligned read zero", 32'h0);
        rd_lit('h040, "R2 unmapped read zero", 32'h0);

        // R5: output enable and level follow the word
        wr('h100 + 4*5, 32'h0880_0001);
        idle(1);
        chk("R5 pin5 oe", {31'b0, pin_oe[5]}, 32'h1);
        chk("R5 pin5 out", {31'b0, pin_out[5]}, 32'h1);

        // R4: writable mask and read-only bit 1
        wr('h100 + 4*6, 32'hFFFF_FFFF);
        rd_lit('h100 + 4*6, "R4 all-ones write", WMASK);
        wr('h100 + 4*6, RSTW);

        // R6: synchronizer latency on pin 10 (mode off)
        @(negedge clk); pin_in[10] = 1'b1;
        rd_lit('h100 + 4*10, "R6 after one edge", RSTW);
        rd_lit('h100 + 4*10, "R6 after two edges", RSTW | 32'h2);

        // R7: level mode on pin 40 (word 1 bit 8)
        wr('h28, 32'h0000_0100);
        wr('h100 + 4*40, 32'h0800_4008);
        @(negedge clk); pin_in[40] = 1'b1;
        idle(3);
        rd_lit('h18, "R7 level status set", 32'h100);
        chk("R12 irq with enable", {31'b0, irq}, 32'h1);
        wr('h18, 32'h0000_0100);
        rd_lit('h18, "R7 clear while high stays set", 32'h100);
        @(negedge clk); pin_in[40] = 1'b0;
        idle(3);
        wr('h18, 32'h0000_0100);
        rd_lit('h18, "R11 write-one clears", 32'h0);
        chk("R12 irq dropped", {31'b0, irq}, 32'h0);

        // R8: edge mode on pin 70 (word 2 bit 6)
        wr('h2C, 32'h0000_0040);
        wr('h100 + 4*70, 32'h0840_4008);
        @(negedge clk); pin_in[70] = 1'b1;
        idle(3);
        rd_lit('h1C, "R8 edge status set", 32'h40);
        wr('h1C, 32'h0000_0040);
        idle(3);
        rd_lit('h1C, "R8 stays clear while high", 32'h0);
        @(negedge clk); pin_in[70] = 1'b0;
        idle(3);
        @(negedge clk); pin_in[70] = 1'b1;
        idle(3);
        rd_lit('h1C, "R8 second rise sets", 32'h40);

        // R12: status without enable gives no request
        wr('h2C, 32'h0);
        idle(1);
        chk("R12 masked irq", {31'b0, irq}, 32'h0);

        // R9, R10, R4: mode off, zero select, receiver off
        wr('h100 + 4*71, 32'h0880_4008);
        wr('h100 + 4*72, 32'h0800_0008);
        wr('h100 + 4*73, 32'h0800_4018);
        @(negedge clk); pin_in[73:71] = 3'b111;
        idle(4);
        rd_lit('h1C, "R9 R10 no status from 71..73", 32'h40);
        rd_lit('h100 + 4*73, "R4 receiver off reads bit1 zero", 32'h0800_4018);
        rd_lit('h100 + 4*71, "R4 bit1 shows input", 32'h0880_400A);

        // R3: lock pin 65 (word 2 bit 1)
        wr('h100 + 4*65, 32'h0800_4008);
        wr('h0C, 32'h0000_0002);
        wr('h100 + 4*65, 32'h0000_0001);
        rd_lit('h100 + 4*65, "R3 locked word unchanged", 32'h0800_4008);
        wr('h0C, 32'h0);
        rd_lit('h0C, "R3 lock sticky", 32'h2);
        wr('h100 + 4*66, 32'h0000_0001);
        rd_lit('h100 + 4*66, "R3 neighbour still writable", 32'h0000_0001);

        // Mixed traffic on pins 96..127 against the model (R4, R7, R8, R11)
        for (int i = 0; i < 400; i++) begin
            seed = xs(seed);
            @(negedge clk);
            pin_in[96 + int'(seed[4:0])] = ~pin_in[96 + int'(seed[4:0])];
            case (seed[7:5])
                3'd0: wr('h100 + 4*(96 + int'(seed[12:8])), xs(seed));
                3'd1: wr('h20, xs(seed));
                3'd2: wr('h30, xs(seed));
                3'd3: rd_chk('h100 + 4*(96 + int'(seed[12:8])), "R4 random pin word");
                3'd4: rd_chk('h20, "R11 random status word");
                3'd5: if (seed[15:8] == 8'h0) wr('h10, 32'(1) << seed[20:16]);
                      else rd_chk('h30, "R11 random enable word");
                default: idle(1);
            endcase
        end
        rd_chk('h10, "R3 lock word 3 after traffic");

        idle(2);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule